// File: doc/BRIEF.md
# Age-Ordered Ready Scheduler

This block tracks a small pool of waiting micro-operations and hands a shared execution resource to the one that has waited longest among those able to run. An allocator places each new operation into a free slot, together with the tag of the operand it waits for. Result tags are broadcast on a writeback bus. Every slot compares the broadcast tag with its stored tag in parallel, and a slot whose tag matches becomes ready.

Arrival order is not tied to slot numbers. Each slot keeps a row in an N-by-N age matrix. When a slot is allocated, its row marks every slot already occupied as older, and its column is cleared in every other row, so the new slot is the youngest. When the resource is free, a combinational picker grants the ready slot that no other ready slot is older than. The grant is one-hot, and the granted slot is freed at the next clock edge.

The allocator reads `slot_busy` to find free slots. It never allocates a slot that is busy and not granted in the same cycle, and it never drives a slot index outside the pool.

Top module: `age_ready_sched`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `slot_busy` is all zeros and `grant` stays all zeros until new entries are allocated and made ready.
- R2: While `res_avail` is 0, `grant` is all zeros.
- R3: `grant` never has more than one bit set; bit i selects slot i.
- R4: A `grant` bit is set only for a slot that is busy and ready.
- R5: A busy slot becomes ready at the clock edge where `wb_valid` is 1 and `wb_tag` equals its stored tag. It can be granted from the cycle after that edge. A broadcast with a different tag, or with `wb_valid` at 0, leaves the slot not ready.
- R6: When several slots are ready, the grant goes to the one allocated earliest, whatever its slot index.
- R7: A granted slot reads as free in `slot_busy` from the next clock edge, unless it is allocated again in the same cycle.
- R8: When an allocation and a matching writeback broadcast occur in the same cycle, the slot is written as ready and can be granted in the following cycle.
- R9: When `res_avail` is 1 and at least one slot is ready, exactly one grant is issued.
- R10: An allocation sets the slot's `slot_busy` bit at the next edge. The slot is not ready unless a matching broadcast arrives. An allocation into the slot being granted in the same cycle takes effect.
- R11: A slot that is reallocated after its grant ranks as younger than every slot that was already busy when it was reallocated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Write a new entry this cycle |
| alloc_slot | input | IDX_W (4) | Slot index for the new entry |
| alloc_tag | input | TAG_W (6) | Operand tag that the new entry waits for |
| wb_valid | input | 1 | A writeback tag is broadcast this cycle |
| wb_tag | input | TAG_W (6) | Broadcast writeback tag |
| res_avail | input | 1 | The shared resource can accept an operation this cycle |
| grant | output | ENTRIES (10) | One-hot selection of the oldest ready slot |
| slot_busy | output | ENTRIES (10) | Occupancy per slot |

## Verification
The bench builds the block with its defaults: 10 slots and 6-bit tags. With this size it can fill every slot, drain them, and place arrival order against slot index in many different arrangements. These include allocation in descending and scattered index order, and slots freed and reallocated so that a low index becomes the youngest. Small tag values make deliberate mismatches and shared tags easy, so a single broadcast can wake several slots together. A reference model keeps a sequence number per slot and predicts every grant and every occupancy bit in every cycle.

// File: rtl/sched_pkg.sv
// Package: shared defaults and helpers for the age-ordered scheduler.
// Assumes: nothing; holds only constants and pure functions.
package sched_pkg;
    parameter int unsigned DEF_ENTRIES = 10;
    parameter int unsigned DEF_TAG_W   = 6;

    // Index width of at least one bit for a pool of n slots.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sched_slot_array.sv
// Module: per-slot storage of occupancy, operand tag and ready flag.
// Every slot compares the writeback tag with its stored tag in parallel.
// Assumes: alloc_hit is one-hot or zero; grant is one-hot or zero.
module sched_slot_array #(
    parameter int unsigned ENTRIES = 10,
    parameter int unsigned TAG_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] alloc_hit,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic               wb_valid,
    input  logic [TAG_W-1:0]   wb_tag,
    input  logic [ENTRIES-1:0] grant,
    output logic [ENTRIES-1:0] slot_valid,
    output logic [ENTRIES-1:0] slot_ready
);
    logic [ENTRIES-1:0] rdy_q;
    logic [ENTRIES-1:0] tag_match;
    logic               alloc_match;

    // Purpose: an incoming entry whose tag is broadcast in the same cycle.
    assign alloc_match = wb_valid && (wb_tag == alloc_tag);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [TAG_W-1:0] tag_q;

        // Purpose: content-addressed compare of the stored tag with the broadcast.
        assign tag_match[i] = wb_valid && (tag_q == wb_tag);

        // Purpose: hold the operand tag of the entry in this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)            tag_q <= '0;
            else if (alloc_hit[i]) tag_q <= alloc_tag;
        end

        // Purpose: occupancy; allocation wins over the release by a grant.
        always_ff @(posedge clk) begin
            if (!rst_n)            slot_valid[i] <= 1'b0;
            else if (alloc_hit[i]) slot_valid[i] <= 1'b1;
            else if (grant[i])     slot_valid[i] <= 1'b0;
        end

        // Purpose: ready flag; set by a tag match, cleared on grant or allocation.
        always_ff @(posedge clk) begin
            if (!rst_n)                             rdy_q[i] <= 1'b0;
            else if (alloc_hit[i])                  rdy_q[i] <= alloc_match;
            else if (grant[i])                      rdy_q[i] <= 1'b0;
            else if (slot_valid[i] && tag_match[i]) rdy_q[i] <= 1'b1;
        end

        // R5: a busy slot that sees a matching broadcast is ready one edge later.
        a_r5_match_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[i] && !grant[i] && !alloc_hit[i] && tag_match[i] |=> slot_ready[i]);

        // R8: allocation together with a matching broadcast gives a ready slot.
        a_r8_alloc_match_ready: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_hit[i] && alloc_match |=> slot_ready[i]);
    end

    // Purpose: a slot that is not occupied is never ready.
    assign slot_ready = rdy_q & slot_valid;
endmodule

// File: rtl/sched_age_matrix.sv
// Module: N-by-N age matrix. Bit [i][j] set means slot j is older than slot i.
// On allocation of slot i, row i marks every busy slot as older and
// column i is cleared in all other rows, so slot i is the youngest.
// Assumes: alloc_hit is one-hot or zero. Bits for free slots may be stale;
// they are overwritten when that slot is allocated again.
module sched_age_matrix #(
    parameter int unsigned ENTRIES = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              alloc_hit,
    input  logic [ENTRIES-1:0]              slot_valid,
    output logic [ENTRIES-1:0][ENTRIES-1:0] older
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_row
        for (genvar j = 0; j < ENTRIES; j++) begin : g_col
            if (i == j) begin : g_diag
                // Purpose: a slot is never older than itself.
                assign older[i][j] = 1'b0;
            end else begin : g_cell
                // Purpose: row write on own allocation, column clear on the other's.
                always_ff @(posedge clk) begin
                    if (!rst_n)            older[i][j] <= 1'b0;
                    else if (alloc_hit[i]) older[i][j] <= slot_valid[j] && !alloc_hit[j];
                    else if (alloc_hit[j]) older[i][j] <= 1'b0;
                end

                // R6: two busy slots always have exactly one order between them.
                a_r6_order_total: assert property (@(posedge clk) disable iff (!rst_n)
                    slot_valid[i] && slot_valid[j] |-> older[i][j] != older[j][i]);

                // R11: a new entry is younger than every slot already busy.
                a_r11_alloc_youngest: assert property (@(posedge clk) disable iff (!rst_n)
                    alloc_hit[i] && slot_valid[j] && !alloc_hit[j] |=> older[i][j] && !older[j][i]);
            end
        end
    end
endmodule

// File: rtl/sched_oldest_pick.sv
// Module: combinational oldest-ready picker.
// Slot i wins when it is ready and every other ready slot is younger than it.
// Assumes: the age matrix gives a total order over the busy slots.
module sched_oldest_pick #(
    parameter int unsigned ENTRIES = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              slot_ready,
    input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
    input  logic                            res_avail,
    output logic [ENTRIES-1:0]              grant
);
    // Purpose: grant slot i if no other ready slot is older than it.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic beats_all;
            beats_all = 1'b1;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && slot_ready[j] && !older[j][i]) beats_all = 1'b0;
            end
            grant[i] = res_avail && slot_ready[i] && beats_all;
        end
    end

    // R3: at most one grant per cycle.
    a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: a free resource and any ready slot give a grant.
    a_r9_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        res_avail && (slot_ready != '0) |-> grant != '0);
endmodule

// File: rtl/age_ready_sched.sv
// Module: top of the age-ordered ready scheduler.
// Decodes the allocation index, wires slot storage, age matrix and picker.
// Assumes: the allocator never targets a busy slot unless it is granted in
// the same cycle, and never drives an index at or above ENTRIES.
module age_ready_sched #(
    parameter int unsigned ENTRIES = sched_pkg::DEF_ENTRIES,
    parameter int unsigned TAG_W   = sched_pkg::DEF_TAG_W,
    localparam int unsigned IDX_W  = sched_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [IDX_W-1:0]   alloc_slot,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic               wb_valid,
    input  logic [TAG_W-1:0]   wb_tag,
    input  logic               res_avail,
    output logic [ENTRIES-1:0] grant,
    output logic [ENTRIES-1:0] slot_busy
);
    logic [ENTRIES-1:0]              alloc_hit;
    logic [ENTRIES-1:0]              slot_ready;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_dec
        // Purpose: one-hot decode of the allocation slot index.
        assign alloc_hit[i] = alloc_valid && (alloc_slot == IDX_W'(i));
    end

    sched_slot_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_hit  (alloc_hit),
        .alloc_tag  (alloc_tag),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .grant      (grant),
        .slot_valid (slot_busy),
        .slot_ready (slot_ready)
    );

    sched_age_matrix #(.ENTRIES(ENTRIES)) age_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_hit  (alloc_hit),
        .slot_valid (slot_busy),
        .older      (older)
    );

    sched_oldest_pick #(.ENTRIES(ENTRIES)) pick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_ready (slot_ready),
        .older      (older),
        .res_avail  (res_avail),
        .grant      (grant)
    );

    // R2: no grant while the resource is busy.
    a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !res_avail |-> grant == '0);

    // R4: grants only go to busy, ready slots.
    a_r4_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(slot_busy & slot_ready)) == '0);

    // R7: a granted slot that is not reallocated is free after the edge.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~alloc_hit) != '0 |=> (slot_busy & $past(grant & ~alloc_hit)) == '0);

    // R10: an allocated slot is busy after the edge.
    a_r10_alloc_busy: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> (slot_busy & $past(alloc_hit)) == $past(alloc_hit));
endmodule

// File: tb/age_ready_sched_tb_top.sv
`timescale 1ns/1ps
module age_ready_sched_tb_top;
    localparam int N  = 10;
    localparam int TW = 6;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [IW-1:0] alloc_slot = '0;
    logic [TW-1:0] alloc_tag = '0;
    logic          wb_valid = 1'b0;
    logic [TW-1:0] wb_tag = '0;
    logic          res_avail = 1'b0;
    logic [N-1:0]  grant;
    logic [N-1:0]  slot_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state: occupancy, readiness, tag and arrival number per slot
    bit          m_valid [N];
    bit          m_ready [N];
    int unsigned m_tag   [N];
    int unsigned m_seq   [N];
    int unsigned seq_ctr = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    age_ready_sched dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
        .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .res_avail(res_avail), .grant(grant), .slot_busy(slot_busy)
    );

    // stimulus row: alloc_v, slot[4], tag[6], wb_v, wbtag[6], avail, expected grant[10]
    localparam int ROWS = 8;
    localparam logic [28:0] TBL [ROWS] = '{
        {1'b1, 4'd5, 6'd3, 1'b0, 6'd0, 1'b1, 10'b0000000000},
        {1'b1, 4'd2, 6'd7, 1'b0, 6'd0, 1'b1, 10'b0000000000},
        {1'b0, 4'd0, 6'd0, 1'b1, 6'd7, 1'b1, 10'b0000000000},
        {1'b0, 4'd0, 6'd0, 1'b1, 6'd3, 1'b0, 10'b0000000000},
        {1'b0, 4'd0, 6'd0, 1'b0, 6'd0, 1'b1, 10'b0000100000},
        {1'b1, 4'd5, 6'd9, 1'b1, 6'd9, 1'b1, 10'b0000000100},
        {1'b0, 4'd0, 6'd0, 1'b0, 6'd0, 1'b1, 10'b0000100000},
        {1'b0, 4'd0, 6'd0, 1'b0, 6'd0, 1'b1, 10'b0000000000}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_grant(input bit avail);
        int best;
        best = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_ready[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
        return (avail && best >= 0) ? (N'(1) << best) : '0;
    endfunction

    function automatic logic [N-1:0] model_busy();
        logic [N-1:0] b;
        for (int i = 0; i < N; i++) b[i] = m_valid[i];
        return b;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ready[i] = 0; m_tag[i] = 0; m_seq[i] = 0;
        end
    endtask

    // one cycle: drive, compare before the edge, advance the model across the edge
    task automatic step(input bit av, input int slot, input int tag, input bit wv, input int wt,
                        input bit avail, input string req, input bit use_exp, input logic [N-1:0] texp);
        logic [N-1:0] eg;
        @(negedge clk);
        alloc_valid = av; alloc_slot = IW'(slot); alloc_tag = TW'(tag);
        wb_valid = wv; wb_tag = TW'(wt); res_avail = avail;
        #1;
        eg = model_grant(avail);
        check(req, "grant", 32'(grant), 32'(eg));
        check(req, "slot_busy", 32'(slot_busy), 32'(model_busy()));
        if (use_exp) check(req, "grant vs table", 32'(grant), 32'(texp));
        for (int i = 0; i < N; i++) begin
            if (eg[i]) begin m_valid[i] = 0; m_ready[i] = 0; end
            if (av && slot == i) begin
                m_valid[i] = 1; m_tag[i] = tag; m_seq[i] = seq_ctr;
                m_ready[i] = wv && (wt == tag);
            end else if (m_valid[i] && wv && m_tag[i] == wt) begin
                m_ready[i] = 1;
            end
        end
        if (av) seq_ctr++;
        @(posedge clk);
    endtask

    task automatic idle(input bit avail, input string req);
        step(0, 0, 0, 0, 0, avail, req, 0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; alloc_valid = 0; wb_valid = 0; res_avail = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset();
        // R1: nothing busy, no grant after reset even with the resource free
        idle(1, "R1");
        idle(1, "R1");

        // table walk: R2 hold, R5 wake, R6 age order, R7 release, R8 alloc+match
        for (int r = 0; r < ROWS; r++) begin
            logic [28:0] v;
            v = TBL[r];
            step(v[28], int'(v[27:24]), int'(v[23:18]), v[17], int'(v[16:11]), v[10],
                 "R2/R6/R8 table", 1, v[9:0]);
        end

        // R5: a wrong tag and a tag with wb_valid low wake nothing
        step(1, 0, 10, 0, 0, 1, "R10", 0, '0);
        step(0, 0, 0, 1, 11, 1, "R5", 0, '0);
        step(0, 0, 0, 0, 10, 1, "R5", 0, '0);
        idle(1, "R5");
        step(0, 0, 0, 1, 10, 1, "R5", 0, '0);
        idle(1, "R5");
        idle(1, "R7");

        // R6: allocate in scattered index order, wake all with one tag
        step(1, 9, 5, 0, 0, 0, "R6", 0, '0);
        step(1, 0, 5, 0, 0, 0, "R6", 0, '0);
        step(1, 4, 5, 0, 0, 0, "R6", 0, '0);
        step(1, 7, 5, 0, 0, 0, "R6", 0, '0);
        step(0, 0, 0, 1, 5, 0, "R6", 0, '0);
        idle(0, "R2");
        for (int k = 0; k < 5; k++) idle(1, "R6");

        // R11 and R10: reallocate a slot while it is granted; it becomes youngest
        step(1, 1, 2, 0, 0, 0, "R11", 0, '0);
        step(1, 3, 2, 0, 0, 0, "R11", 0, '0);
        step(0, 0, 0, 1, 2, 0, "R11", 0, '0);
        step(1, 1, 2, 1, 2, 1, "R10", 0, '0);
        idle(1, "R11");
        idle(1, "R11");
        idle(1, "R7");

        // R9: fill every slot, wake them, drain one per cycle
        for (int s = 0; s < N; s++) step(1, s, 1, 0, 0, 0, "R10", 0, '0);
        step(0, 0, 0, 1, 1, 0, "R5", 0, '0);
        for (int k = 0; k < N + 1; k++) idle(1, "R9");

        // R1: reset while slots are busy and ready
        step(1, 6, 4, 1, 4, 0, "R8", 0, '0);
        step(1, 2, 4, 0, 0, 0, "R10", 0, '0);
        do_reset();
        idle(1, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule